// File: doc/BRIEF.md
# Receive Packet Buffer with Overflow and Flush Discard

This block sits between a network receive path and a host read port, in one clock domain. It stores incoming frames as 32-bit words and tags the last word of each frame with an end marker. The host sees a word on the read side only after the whole frame containing it has been written. This means a frame is never exposed to the host partly written.

Two events throw away the whole buffer. The first is an overflow, which happens when a frame word arrives and no room is left. The second is a one-cycle flush request from the host. Both events drop every stored frame as well as the frame being written. After either event, writing resumes only at the next start-of-frame strobe. Any remaining words of the interrupted frame are dropped. An overflow also sets a sticky status flag, which clears when the host reads it.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After synchronous reset, `rd_valid` and `ovf_flag` are 0.
- R2: Words of a frame are not offered on the read side (`rd_valid` stays 0) until the word carrying `wr_eof` has been written. The frame becomes readable in the cycle after that word's clock edge.
- R3: Frames are read back in write order, word for word. `rd_eop` is 1 only on each frame's last word. While `rd_ready` is 0, `rd_data` and `rd_eop` hold their values.
- R4: While no frame is open, a valid word without `wr_sof` is dropped and stores nothing.
- R5: The buffer holds 512 words. A frame that exactly fills it is kept whole and does not set `ovf_flag`.
- R6: A frame word that arrives while 512 words are occupied is not stored. On that edge every buffered word is discarded, so `rd_valid` is 0 afterwards, and `ovf_flag` is set.
- R7: After an overflow, the remaining words of that frame are dropped. Storing restarts with the next word that carries `wr_sof`.
- R8: `ovf_flag` stays set until a cycle with `stat_rd` high clears it. If an overflow and `stat_rd` fall in the same cycle, the flag ends up set.
- R9: A cycle with `flush_wr` high discards all stored frames and the open frame. It also drops the word written in that cycle. Later words of the open frame are dropped until the next `wr_sof`.
- R10: A `wr_sof` word that arrives while a frame is still open discards only the open partial frame. It then starts a new frame, and complete frames stored earlier are kept.
- R11: A single word carrying both `wr_sof` and `wr_eof` forms a one-word frame, which is read with `rd_eop` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 32 | Incoming frame word |
| wr_valid | input | 1 | Incoming word present |
| wr_sof | input | 1 | Word is the first of a frame |
| wr_eof | input | 1 | Word is the last of a frame |
| flush_wr | input | 1 | Host writes the flush control bit (one-cycle pulse) |
| stat_rd | input | 1 | Host reads the status flag (clears it) |
| ovf_flag | output | 1 | Sticky overflow status |
| rd_data | output | 32 | Word offered to the host |
| rd_valid | output | 1 | `rd_data` belongs to a fully stored frame |
| rd_eop | output | 1 | Offered word is the last of its frame |
| rd_ready | input | 1 | Host takes the offered word |

## Verification
The collision of interest is an overflow and a status read landing on the same edge. The bench first fills the buffer with one 512-word frame. It then presents a new start-of-frame word with `stat_rd` held high in that same cycle. After that edge, the flag must read 1, showing that the set wins, and `rd_valid` must be 0. A later status read on its own must then clear the flag. The bench also pairs a flush pulse with a frame word in the same cycle, and judges that the word is absent from everything read afterwards.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int WORD_W = 32;

    typedef enum logic {
        S_HUNT = 1'b0,
        S_RECV = 1'b1
    } wr_state_e;

    typedef struct packed {
        logic              eop;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    function automatic logic [15:0] ptr_gap(input logic [15:0] head, input logic [15:0] tail);
        return head - tail;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  rx_word_t          wword,
    input  logic [ADDR_W-1:0] raddr,
    output rx_word_t          rword
);
    rx_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wword;
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic              flush_wr,
    input  logic [PTR_W-1:0]  rptr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              ovf_evt,
    output logic              clr,
    output logic [PTR_W-1:0]  cptr
);
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    wr_state_e        state;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] base;
    logic             take;
    logic             restart;
    logic             full;

    always_comb begin
        restart = (state == S_RECV) && wr_sof;
        take    = wr_valid && (wr_sof || state == S_RECV);
        base    = restart ? cptr : wptr;
        full    = PTR_W'(ptr_gap(16'(base), 16'(rptr))) == FULL_CNT;
        ovf_evt = !flush_wr && take && full;
        we      = !flush_wr && take && !full;
        clr     = flush_wr || ovf_evt;
        waddr   = base[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_HUNT;
            wptr  <= '0;
            cptr  <= '0;
        end else if (clr) begin
            state <= S_HUNT;
            wptr  <= '0;
            cptr  <= '0;
        end else if (we) begin
            wptr <= base + 1'b1;
            if (wr_eof) begin
                cptr  <= base + 1'b1;
                state <= S_HUNT;
            end else begin
                state <= S_RECV;
            end
        end
    end

    // R2: no partially written words exist while no frame is open
    p_hunt_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_HUNT) |-> (wptr == cptr));

    // R5: occupancy never exceeds the buffer depth
    p_occupancy_r5: assert property (@(posedge clk) disable iff (rst)
        (wptr - rptr) <= FULL_CNT);

    // R4: a stray word outside a frame leaves the write pointer alone
    p_stray_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_HUNT && wr_valid && !wr_sof) |=> $stable(wptr));
endmodule

// File: rtl/rxf_rd_port.sv
module rxf_rd_port
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [PTR_W-1:0]  cptr,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [PTR_W-1:0]  rptr,
    output logic [ADDR_W-1:0] raddr
);
    assign rd_valid = (rptr != cptr);
    assign raddr    = rptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) rptr <= '0;
        else if (rd_valid && rd_ready) rptr <= rptr + 1'b1;
    end

    // R6/R9: a discard leaves nothing readable
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !rd_valid);
endmodule

// File: rtl/rxf_status.sv
module rxf_status (
    input  logic clk,
    input  logic rst,
    input  logic ovf_evt,
    input  logic stat_rd,
    output logic ovf_flag
);
    always_ff @(posedge clk) begin
        if (rst) ovf_flag <= 1'b0;
        else if (ovf_evt) ovf_flag <= 1'b1;
        else if (stat_rd) ovf_flag <= 1'b0;
    end

    // R6: an overflow is always reported
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    // R8: the flag persists until read
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !stat_rd) |=> ovf_flag);
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic              wr_sof,
    input  logic              wr_eof,
    input  logic              flush_wr,
    input  logic              stat_rd,
    output logic              ovf_flag,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_eop,
    input  logic              rd_ready
);
    logic              we;
    logic              ovf_evt;
    logic              clr;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PTR_W-1:0]  cptr;
    logic [PTR_W-1:0]  rptr;
    rx_word_t          wword;
    rx_word_t          rword;

    assign wword = '{eop: wr_eof, data: wr_data};

    rxf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_sof(wr_sof),
        .wr_eof(wr_eof), .flush_wr(flush_wr), .rptr(rptr), .we(we),
        .waddr(waddr), .ovf_evt(ovf_evt), .clr(clr), .cptr(cptr)
    );

    rxf_store #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(we), .waddr(waddr), .wword(wword),
        .raddr(raddr), .rword(rword)
    );

    rxf_rd_port #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst(rst), .clr(clr), .cptr(cptr), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rptr(rptr), .raddr(raddr)
    );

    rxf_status u_st (
        .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .stat_rd(stat_rd),
        .ovf_flag(ovf_flag)
    );

    assign rd_data = rword.data;
    assign rd_eop  = rword.eop;

    // R3: an offered word is held while the host stalls
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready && !clr) |=> (rd_valid && $stable(rd_data) && $stable(rd_eop)));
endmodule

// File: tb/sim_rx_pkt_fifo.sv
module sim_rx_pkt_fifo;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] wr_data;
    logic        wr_valid, wr_sof, wr_eof, flush_wr, stat_rd, rd_ready;
    logic        ovf_flag, rd_valid, rd_eop;
    logic [31:0] rd_data;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rx_pkt_fifo u0 (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_sof(wr_sof), .wr_eof(wr_eof), .flush_wr(flush_wr),
        .stat_rd(stat_rd), .ovf_flag(ovf_flag), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_eop(rd_eop), .rd_ready(rd_ready)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic put(input logic [31:0] d, input logic s, input logic e);
        @(negedge clk);
        wr_valid = 1'b1; wr_sof = s; wr_eof = e; wr_data = d;
    endtask

    task automatic idle;
        @(negedge clk);
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
        flush_wr = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [31:0] base, input int len, input logic close);
        for (int i = 0; i < len; i++)
            put(base + 32'(i), i == 0, close && (i == len - 1));
        idle();
    endtask

    task automatic read_frame(input logic [31:0] base, input int len, input string req);
        for (int i = 0; i < len; i++) begin
            check(rd_valid && rd_data == base + 32'(i) && rd_eop == (i == len - 1),
                  req, {rd_valid, rd_eop, rd_data}, {1'b1, i == len - 1, base + 32'(i)});
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
        end
    endtask

    task automatic t_reset;
        check(!rd_valid, "R1 rd_valid", rd_valid, 0);
        check(!ovf_flag, "R1 ovf_flag", ovf_flag, 0);
    endtask

    task automatic t_partial_and_order;
        logic [31:0] held;
        send_frame(32'h100, 3, 1'b0);
        check(!rd_valid, "R2 partial hidden", rd_valid, 0);
        put(32'h103, 1'b0, 1'b1);
        idle();
        check(rd_valid, "R2 visible after eof", rd_valid, 1);
        held = rd_data;
        repeat (3) @(negedge clk);
        check(rd_data == held && rd_valid, "R3 held under stall", rd_data, held);
        read_frame(32'h100, 4, "R3 order");
        send_frame(32'h200, 1, 1'b1);
        read_frame(32'h200, 1, "R11 single word");
        check(!rd_valid, "R3 drained", rd_valid, 0);
    endtask

    task automatic t_stray;
        put(32'hDEAD, 1'b0, 1'b0);
        put(32'hBEEF, 1'b0, 1'b1);
        idle();
        check(!rd_valid, "R4 stray dropped", rd_valid, 0);
        send_frame(32'h300, 2, 1'b1);
        read_frame(32'h300, 2, "R4 normal after stray");
    endtask

    task automatic t_fill;
        send_frame(32'h1000, 512, 1'b1);
        check(!ovf_flag, "R5 no overflow at exact fill", ovf_flag, 0);
        read_frame(32'h1000, 512, "R5 full frame");
    endtask

    task automatic t_overflow;
        send_frame(32'h4000, 500, 1'b1);
        for (int i = 0; i < 13; i++) put(32'h5000 + 32'(i), i == 0, 1'b0);
        idle();
        check(!rd_valid, "R6 buffer cleared", rd_valid, 0);
        check(ovf_flag, "R6 flag set", ovf_flag, 1);
        put(32'h500D, 1'b0, 1'b0);
        put(32'h500E, 1'b0, 1'b1);
        idle();
        check(!rd_valid, "R7 tail dropped", rd_valid, 0);
        send_frame(32'h600, 3, 1'b1);
        read_frame(32'h600, 3, "R7 resume at sof");
        check(!rd_valid, "R7 nothing else", rd_valid, 0);
        check(ovf_flag, "R8 sticky", ovf_flag, 1);
        @(negedge clk); stat_rd = 1'b1;
        idle();
        check(!ovf_flag, "R8 read clears", ovf_flag, 0);
    endtask

    task automatic t_set_wins;
        send_frame(32'h7000, 512, 1'b1);
        @(negedge clk);
        wr_valid = 1'b1; wr_sof = 1'b1; wr_eof = 1'b0; wr_data = 32'h8000; stat_rd = 1'b1;
        idle();
        check(ovf_flag, "R8 set wins over read", ovf_flag, 1);
        check(!rd_valid, "R6 cleared on collision", rd_valid, 0);
        @(negedge clk); stat_rd = 1'b1;
        idle();
        check(!ovf_flag, "R8 cleared later", ovf_flag, 0);
    endtask

    task automatic t_flush;
        send_frame(32'h900, 4, 1'b1);
        send_frame(32'hA00, 2, 1'b0);
        @(negedge clk);
        wr_valid = 1'b1; wr_sof = 1'b0; wr_eof = 1'b0; wr_data = 32'hA02; flush_wr = 1'b1;
        idle();
        check(!rd_valid, "R9 flush empties", rd_valid, 0);
        put(32'hA03, 1'b0, 1'b1);
        idle();
        check(!rd_valid, "R9 open frame dropped", rd_valid, 0);
        check(!ovf_flag, "R9 no overflow flag", ovf_flag, 0);
        send_frame(32'hB00, 2, 1'b1);
        read_frame(32'hB00, 2, "R9 resume after flush");
    endtask

    task automatic t_restart;
        send_frame(32'hC00, 2, 1'b1);
        send_frame(32'hD00, 3, 1'b0);
        send_frame(32'hE00, 2, 1'b1);
        read_frame(32'hC00, 2, "R10 earlier frame kept");
        read_frame(32'hE00, 2, "R10 new frame");
        check(!rd_valid, "R10 partial gone", rd_valid, 0);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0; wr_data = '0;
        flush_wr = 1'b0; stat_rd = 1'b0; rd_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_partial_and_order();
        t_stray();
        t_fill();
        t_overflow();
        t_set_wins();
        t_flush();
        t_restart();
        summary();
    end
endmodule